// File: doc/BRIEF.md
# Combinational 32-point Complex Fast Fourier Transform

This block computes a 32-point forward discrete Fourier transform on complex fixed-point samples in a single combinational pass. It has no clock and no registers. All 32 time-domain samples arrive in parallel on two flat buses, one for the real parts and one for the imaginary parts. The 32 frequency bins appear on two output buses of the same shape.

Inside, the samples pass through a bit-reversed index permutation and then through five layers of radix-2 decimation-in-time butterflies, with sixteen butterflies in each layer. Each butterfly rotates its lower operand by a constant twiddle factor, using a complex fixed-point multiply, and then forms the sum and the difference with its upper operand. The twiddle constants are computed at elaboration and rounded to the nearest step of the coefficient format.

Arithmetic wraps on overflow. Nothing saturates or rescales between layers. A system that feeds the block must keep its transform results within the data range, or accept wrapped results.

Top module: `fft32_comb`

## Requirements
- R1: Sample n sits on the input bus, and bin k on the output bus, in natural index order. Element k occupies bits [k*23 +: 23]. For an impulse of value A at index n, bin k equals A·e^(−j2πnk/32) within the R7 tolerance.
- R2: An impulse placed at index 0 gives every one of the 32 output bins exactly the impulse value, in both the real and the imaginary part.
- R3: A constant input v on all samples gives exactly 32·v in bin 0 and exactly zero in every other bin. An all-zero input gives all-zero outputs.
- R4: Bin 0 always equals, bit for bit, the sum of all 32 inputs wrapped to 23 bits.
- R5: Bin 16 always equals, bit for bit, the wrapped sum of the inputs with alternating signs (+x0 −x1 +x2 …).
- R6: Bin 8 always equals, bit for bit, the wrapped sum of x[n]·(−j)^n. Bin 24 always equals, bit for bit, the wrapped sum of x[n]·(+j)^n.
- R7: Data words are 23-bit two's complement with 10 fraction bits (1.0 = 1024 counts). When every true bin value stays within the range, each output component lies within 32 counts of a double-precision DFT of the same quantized inputs.
- R8: Results that leave the ±4096 range wrap modulo 2^23 and do not saturate. With every sample equal to 200.0 + j0, bin 0 reads −1835008 counts.
- R9: The outputs follow a change on the inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_re | input | 736 | Real parts of the 32 time samples, sample n at bits [n*23 +: 23] |
| x_im | input | 736 | Imaginary parts of the 32 time samples, same layout |
| y_re | output | 736 | Real parts of the 32 frequency bins, bin k at bits [k*23 +: 23] |
| y_im | output | 736 | Imaginary parts of the 32 frequency bins, same layout |

## Verification
The bound checker checks the bit-exact results whenever the inputs settle. These are bin 0, bin 16, bins 8 and 24, and the all-zero case. Those bins reach the output only through twiddles of ±1 and ±j, so they carry no rounding error. They are exact for any input, including inputs that overflow.

The accuracy of every other bin depends on twiddle rounding and product truncation. That can only be judged against a floating-point reference, so the bench shows it with its impulse, constant and tone scenarios. The bench also shows the port ordering, the wrap on overflow, and the exact impulse and constant responses.

// File: rtl/fft_comb_pkg.sv
package fft_comb_pkg;

   localparam real PI_C = 3.14159265358979323846;

   // Reverse the low 'bits' bits of v.
   function automatic int bit_rev(input int v, input int bits);
      int r;
      r = 0;
      for (int i = 0; i < bits; i++) begin
         if (((v >> i) & 1) != 0) r = r | (1 << (bits - 1 - i));
      end
      return r;
   endfunction

   // Real part of e^(-j*2*pi*k/n), rounded to 'frac' fraction bits.
   function automatic int tw_cos(input int k, input int n, input int frac);
      real v;
      v = $cos(2.0 * PI_C * k / n) * (2.0 ** frac);
      return $rtoi($floor(v + 0.5));
   endfunction

   // Imaginary part of e^(-j*2*pi*k/n), rounded to 'frac' fraction bits.
   function automatic int tw_sin_neg(input int k, input int n, input int frac);
      real v;
      v = -$sin(2.0 * PI_C * k / n) * (2.0 ** frac);
      return $rtoi($floor(v + 0.5));
   endfunction

endpackage

// File: rtl/fft_cmul.sv
module fft_cmul #(
   parameter int DATA_W = 23,
   parameter int TW_W   = 12,
   parameter int FRAC_W = 10
) (
   input  logic signed [DATA_W-1:0] b_re,
   input  logic signed [DATA_W-1:0] b_im,
   input  logic signed [TW_W-1:0]   w_re,
   input  logic signed [TW_W-1:0]   w_im,
   output logic signed [DATA_W-1:0] p_re,
   output logic signed [DATA_W-1:0] p_im
);
   localparam int PW = DATA_W + TW_W;

   logic signed [PW-1:0]     m_rr, m_ii, m_ri, m_ir;
   logic signed [DATA_W-1:0] t_rr, t_ii, t_ri, t_ir;

   // Four real products, each truncated to the data width before combining.
   always_comb begin
      m_rr = PW'(b_re) * PW'(w_re);
      m_ii = PW'(b_im) * PW'(w_im);
      m_ri = PW'(b_im) * PW'(w_re);
      m_ir = PW'(b_re) * PW'(w_im);
      t_rr = DATA_W'(m_rr >>> FRAC_W);
      t_ii = DATA_W'(m_ii >>> FRAC_W);
      t_ri = DATA_W'(m_ri >>> FRAC_W);
      t_ir = DATA_W'(m_ir >>> FRAC_W);
      p_re = t_rr - t_ii;
      p_im = t_ri + t_ir;
   end
endmodule

// File: rtl/fft_bfly.sv
module fft_bfly #(
   parameter int DATA_W = 23,
   parameter int TW_W   = 12,
   parameter int FRAC_W = 10
) (
   input  logic signed [DATA_W-1:0] a_re,
   input  logic signed [DATA_W-1:0] a_im,
   input  logic signed [DATA_W-1:0] b_re,
   input  logic signed [DATA_W-1:0] b_im,
   input  logic signed [TW_W-1:0]   w_re,
   input  logic signed [TW_W-1:0]   w_im,
   output logic signed [DATA_W-1:0] s_re,
   output logic signed [DATA_W-1:0] s_im,
   output logic signed [DATA_W-1:0] d_re,
   output logic signed [DATA_W-1:0] d_im
);
   logic signed [DATA_W-1:0] rot_re, rot_im;

   fft_cmul #(.DATA_W(DATA_W), .TW_W(TW_W), .FRAC_W(FRAC_W)) u_mul (
      .b_re(b_re), .b_im(b_im), .w_re(w_re), .w_im(w_im),
      .p_re(rot_re), .p_im(rot_im)
   );

   // Sum and difference wrap silently on overflow.
   assign s_re = a_re + rot_re;
   assign s_im = a_im + rot_im;
   assign d_re = a_re - rot_re;
   assign d_im = a_im - rot_im;
endmodule

// File: rtl/fft_stage.sv
module fft_stage
   import fft_comb_pkg::*;
#(
   parameter int DATA_W = 23,
   parameter int TW_W   = 12,
   parameter int FRAC_W = 10,
   parameter int LOG2N  = 5,
   parameter int STAGE  = 0
) (
   input  logic [(1<<LOG2N)-1:0][DATA_W-1:0] in_re,
   input  logic [(1<<LOG2N)-1:0][DATA_W-1:0] in_im,
   output logic [(1<<LOG2N)-1:0][DATA_W-1:0] out_re,
   output logic [(1<<LOG2N)-1:0][DATA_W-1:0] out_im
);
   localparam int NPTS = 1 << LOG2N;
   localparam int HALF = 1 << STAGE;        // distance between paired elements
   localparam int TSTEP = NPTS / (2 * HALF); // twiddle index step in this layer

   for (genvar b = 0; b < NPTS / 2; b++) begin : g_bf
      localparam int J   = b % HALF;
      localparam int TOP = (b / HALF) * 2 * HALF + J;
      localparam int BOT = TOP + HALF;
      localparam int K   = J * TSTEP;
      localparam logic signed [TW_W-1:0] WR = TW_W'(tw_cos(K, NPTS, FRAC_W));
      localparam logic signed [TW_W-1:0] WI = TW_W'(tw_sin_neg(K, NPTS, FRAC_W));

      fft_bfly #(.DATA_W(DATA_W), .TW_W(TW_W), .FRAC_W(FRAC_W)) u_bf (
         .a_re(in_re[TOP]), .a_im(in_im[TOP]),
         .b_re(in_re[BOT]), .b_im(in_im[BOT]),
         .w_re(WR),         .w_im(WI),
         .s_re(out_re[TOP]), .s_im(out_im[TOP]),
         .d_re(out_re[BOT]), .d_im(out_im[BOT])
      );
   end
endmodule

// File: rtl/fft32_comb.sv
module fft32_comb
   import fft_comb_pkg::*;
#(
   parameter int DATA_W = 23,
   parameter int TW_W   = 12,
   parameter int FRAC_W = 10,
   parameter int LOG2N  = 5
) (
   input  logic [(1<<LOG2N)*DATA_W-1:0] x_re,
   input  logic [(1<<LOG2N)*DATA_W-1:0] x_im,
   output logic [(1<<LOG2N)*DATA_W-1:0] y_re,
   output logic [(1<<LOG2N)*DATA_W-1:0] y_im
);
   localparam int NPTS = 1 << LOG2N;

   // Elaboration-time parameter checks.
   if (FRAC_W >= TW_W - 1) begin : g_bad_tw
      $error("twiddle width must hold +1.0 with sign");
   end
   if (TW_W > DATA_W) begin : g_bad_dw
      $error("twiddle wider than data word");
   end
   if (LOG2N < 2) begin : g_bad_n
      $error("transform needs at least four points");
   end

   for (genvar s = 0; s <= LOG2N; s++) begin : g_lvl
      logic [NPTS-1:0][DATA_W-1:0] d_re, d_im;
      if (s == 0) begin : g_perm
         for (genvar i = 0; i < NPTS; i++) begin : g_pick
            localparam int SRC = bit_rev(i, LOG2N);
            assign d_re[i] = x_re[SRC*DATA_W +: DATA_W];
            assign d_im[i] = x_im[SRC*DATA_W +: DATA_W];
         end
      end else begin : g_layer
         fft_stage #(
            .DATA_W(DATA_W), .TW_W(TW_W), .FRAC_W(FRAC_W),
            .LOG2N(LOG2N), .STAGE(s - 1)
         ) u_st (
            .in_re(g_lvl[s-1].d_re), .in_im(g_lvl[s-1].d_im),
            .out_re(d_re), .out_im(d_im)
         );
      end
   end

   assign y_re = g_lvl[LOG2N].d_re;
   assign y_im = g_lvl[LOG2N].d_im;
endmodule

// File: rtl/fft32_comb_chk.sv
module fft32_comb_chk #(
   parameter int DATA_W = 23,
   parameter int LOG2N  = 5
) (
   input logic [(1<<LOG2N)*DATA_W-1:0] x_re,
   input logic [(1<<LOG2N)*DATA_W-1:0] x_im,
   input logic [(1<<LOG2N)*DATA_W-1:0] y_re,
   input logic [(1<<LOG2N)*DATA_W-1:0] y_im
);
   localparam int NPTS = 1 << LOG2N;
   localparam int QB   = NPTS / 4;
   localparam int HB   = NPTS / 2;
   localparam int TB   = 3 * NPTS / 4;

   always_comb begin
      logic signed [DATA_W-1:0] xr, xi;
      logic signed [DATA_W-1:0] s0r, s0i, shr, shi, sqr, sqi, s3r, s3i;
      s0r = '0; s0i = '0; shr = '0; shi = '0;
      sqr = '0; sqi = '0; s3r = '0; s3i = '0;
      for (int n = 0; n < NPTS; n++) begin
         xr = x_re[n*DATA_W +: DATA_W];
         xi = x_im[n*DATA_W +: DATA_W];
         s0r = s0r + xr;
         s0i = s0i + xi;
         if (n % 2 == 0) begin
            shr = shr + xr; shi = shi + xi;
         end else begin
            shr = shr - xr; shi = shi - xi;
         end
         case (n % 4)
            0: begin sqr = sqr + xr; sqi = sqi + xi; s3r = s3r + xr; s3i = s3i + xi; end
            1: begin sqr = sqr + xi; sqi = sqi - xr; s3r = s3r - xi; s3i = s3i + xr; end
            2: begin sqr = sqr - xr; sqi = sqi - xi; s3r = s3r - xr; s3i = s3i - xi; end
            default: begin sqr = sqr - xi; sqi = sqi + xr; s3r = s3r + xi; s3i = s3i - xr; end
         endcase
      end
      p_dc_bin_r4: assert (y_re[0 +: DATA_W] == s0r && y_im[0 +: DATA_W] == s0i)
         else $error("bin 0 differs from wrapped input sum");
      p_nyq_bin_r5: assert (y_re[HB*DATA_W +: DATA_W] == shr && y_im[HB*DATA_W +: DATA_W] == shi)
         else $error("half-rate bin differs from alternating sum");
      p_quarter_bins_r6: assert (y_re[QB*DATA_W +: DATA_W] == sqr && y_im[QB*DATA_W +: DATA_W] == sqi
                              && y_re[TB*DATA_W +: DATA_W] == s3r && y_im[TB*DATA_W +: DATA_W] == s3i)
         else $error("quarter-rate bins differ from rotated sums");
      p_zero_in_r3: assert (!(x_re == '0 && x_im == '0) || (y_re == '0 && y_im == '0))
         else $error("zero input gave nonzero output");
   end
endmodule

bind fft32_comb fft32_comb_chk #(.DATA_W(DATA_W), .LOG2N(LOG2N)) u_chk (
   .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im)
);

// File: tb/fft32_comb_bench.sv
module fft32_comb_bench;
   localparam int DW = 23;
   localparam int NP = 32;
   localparam int TOL = 32;
   localparam real PI = 3.14159265358979323846;

   // kind (0 impulse, 1 constant, 2 tone), index or bin, amp re, amp im (counts)
   localparam int VEC [6][4] = '{
      '{0, 0, 3072, -1024},
      '{0, 5, 2048, 512},
      '{0, 31, -1536, 2560},
      '{1, 0, 1536, -512},
      '{2, 3, 2048, 0},
      '{2, 29, 1024, 1536}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [NP*DW-1:0] x_re, x_im, y_re, y_im;
   int xr [NP];
   int xi [NP];
   int checks = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   fft32_comb u_fft32_comb (.x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im));

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         checks = checks + 1;
         fails = fails + 1;
         $display("FAIL watchdog: run hung, got %0d cycles expected under 100000", cycles);
         finish_run();
      end
   end

   function automatic int rnd(input real v);
      return $rtoi($floor(v + 0.5));
   endfunction

   function automatic int wrap(input longint v);
      longint m;
      m = v & ((64'sd1 <<< DW) - 1);
      if (m >= (64'sd1 <<< (DW - 1))) m = m - (64'sd1 <<< DW);
      return int'(m);
   endfunction

   function automatic int get_re(input int k);
      return int'($signed(y_re[k*DW +: DW]));
   endfunction
   function automatic int get_im(input int k);
      return int'($signed(y_im[k*DW +: DW]));
   endfunction

   task automatic apply();
      @(negedge clk);
      for (int n = 0; n < NP; n++) begin
         x_re[n*DW +: DW] = DW'(xr[n]);
         x_im[n*DW +: DW] = DW'(xi[n]);
      end
      #2;
   endtask

   task automatic chk_exact(input string tag, input int k, input int er, input int ei);
      checks = checks + 1;
      if (get_re(k) != er || get_im(k) != ei) begin
         fails = fails + 1;
         $display("FAIL %s bin %0d: got (%0d,%0d) expected (%0d,%0d)", tag, k,
                  get_re(k), get_im(k), er, ei);
      end
   endtask

   task automatic chk_near(input string tag, input int k);
      real rr, ri, th, dr, di;
      rr = 0.0; ri = 0.0;
      for (int n = 0; n < NP; n++) begin
         th = 2.0 * PI * k * n / NP;
         rr = rr + xr[n] * $cos(th) + xi[n] * $sin(th);
         ri = ri + xi[n] * $cos(th) - xr[n] * $sin(th);
      end
      dr = $itor(get_re(k)) - rr;
      di = $itor(get_im(k)) - ri;
      if (dr < 0.0) dr = -dr;
      if (di < 0.0) di = -di;
      checks = checks + 1;
      if (dr > TOL || di > TOL) begin
         fails = fails + 1;
         $display("FAIL %s bin %0d: got (%0d,%0d) expected (%0.1f,%0.1f)", tag, k,
                  get_re(k), get_im(k), rr, ri);
      end
   endtask

   initial begin
      x_re = '0;
      x_im = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R3: all-zero input (idle state) gives all-zero outputs
      for (int n = 0; n < NP; n++) begin xr[n] = 0; xi[n] = 0; end
      apply();
      for (int k = 0; k < NP; k++) chk_exact("R3 zero", k, 0, 0);

      // Table walk: R1 ordering and R7 accuracy against a double-precision DFT
      for (int v = 0; v < 6; v++) begin
         for (int n = 0; n < NP; n++) begin
            real th;
            th = 2.0 * PI * VEC[v][1] * n / NP;
            case (VEC[v][0])
               0: begin
                  xr[n] = (n == VEC[v][1]) ? VEC[v][2] : 0;
                  xi[n] = (n == VEC[v][1]) ? VEC[v][3] : 0;
               end
               1: begin xr[n] = VEC[v][2]; xi[n] = VEC[v][3]; end
               default: begin
                  xr[n] = rnd(VEC[v][2] * $cos(th) - VEC[v][3] * $sin(th));
                  xi[n] = rnd(VEC[v][2] * $sin(th) + VEC[v][3] * $cos(th));
               end
            endcase
         end
         apply();
         for (int k = 0; k < NP; k++) chk_near((VEC[v][0] == 0) ? "R1 impulse" : "R7 accuracy", k);
      end

      // R2: impulse at index 0 is copied exactly to every bin
      for (int n = 0; n < NP; n++) begin xr[n] = 0; xi[n] = 0; end
      xr[0] = -2500; xi[0] = 1777;
      apply();
      for (int k = 0; k < NP; k++) chk_exact("R2 impulse0", k, -2500, 1777);

      // R3: constant input lands only in bin 0, exactly
      for (int n = 0; n < NP; n++) begin xr[n] = 3333; xi[n] = -1234; end
      apply();
      chk_exact("R3 dc", 0, 32 * 3333, -32 * 1234);
      for (int k = 1; k < NP; k++) chk_exact("R3 dc", k, 0, 0);

      // R4 R5 R6: exact bins for pseudo-random inputs
      begin
         int seed;
         longint s0r, s0i, shr, shi, sqr, sqi, s3r, s3i;
         seed = 12345;
         for (int t = 0; t < 4; t++) begin
            s0r = 0; s0i = 0; shr = 0; shi = 0; sqr = 0; sqi = 0; s3r = 0; s3i = 0;
            for (int n = 0; n < NP; n++) begin
               seed = seed * 1103515245 + 12345;
               xr[n] = ((seed >>> 8) % 102400);
               seed = seed * 1103515245 + 12345;
               xi[n] = ((seed >>> 8) % 102400);
               s0r += xr[n]; s0i += xi[n];
               shr += (n % 2 == 0) ? xr[n] : -xr[n];
               shi += (n % 2 == 0) ? xi[n] : -xi[n];
               case (n % 4)
                  0: begin sqr += xr[n]; sqi += xi[n]; s3r += xr[n]; s3i += xi[n]; end
                  1: begin sqr += xi[n]; sqi -= xr[n]; s3r -= xi[n]; s3i += xr[n]; end
                  2: begin sqr -= xr[n]; sqi -= xi[n]; s3r -= xr[n]; s3i -= xi[n]; end
                  default: begin sqr -= xi[n]; sqi += xr[n]; s3r += xi[n]; s3i -= xr[n]; end
               endcase
            end
            apply();
            chk_exact("R4 bin0", 0, wrap(s0r), wrap(s0i));
            chk_exact("R5 bin16", 16, wrap(shr), wrap(shi));
            chk_exact("R6 bin8", 8, wrap(sqr), wrap(sqi));
            chk_exact("R6 bin24", 24, wrap(s3r), wrap(s3i));
         end
      end

      // R8: overflow wraps instead of saturating
      for (int n = 0; n < NP; n++) begin xr[n] = 200 * 1024; xi[n] = 0; end
      apply();
      chk_exact("R8 wrap", 0, -1835008, 0);
      chk_exact("R8 wrap", 16, 0, 0);

      // R9: outputs follow an input change between clock edges
      @(posedge clk);
      #3;
      for (int n = 0; n < NP; n++) begin
         xr[n] = 0; xi[n] = 0;
         x_re[n*DW +: DW] = '0;
         x_im[n*DW +: DW] = '0;
      end
      xr[0] = 700;
      x_re[0 +: DW] = DW'(700);
      #1;
      chk_exact("R9 no clock", 0, 700, 0);
      chk_exact("R9 no clock", 31, 700, 0);

      finish_run();
   end
endmodule